// File: doc/BRIEF.md
# Reset Cause and Request Register

This block holds a single 32-bit register that tells software why the system last came out of reset. Software can also use it to ask for a new reset. The register sits on a simple word-wide register bus. Reads are combinational. Writes take effect at the clock edge.

The top five bits carry the causes:

| Bit | Cause |
|-----|-------|
| 31 | Power-on |
| 30 | Software power-on request |
| 29 | Software external-initiated request |
| 28 | Button power-on |
| 27 | Button external-initiated |

Bits 31, 28 and 27 are status bits that software clears by writing one. Bits 30 and 29 are request bits that software sets by writing one. Setting either request bit makes the block send a one-cycle reset request pulse to the reset controller.

The reset controller answers with a one-cycle pulse on the event input each time a reset takes place. A saturating counter counts these events. While the counter is zero, the next event overwrites the register with the power-on pattern. A software power-on request zeroes the counter, so the reset it causes is reported as power-on again.

The register occupies the upper word of an 8-byte slot whose base address is a parameter. The lower word of the slot, and every other address, reads zero and ignores writes.

Top module: `rst_cause_reg`

## Requirements
- R1: After the asynchronous reset `rst_n`, the register reads 0x00000000 and `sys_rst_req` is low.
- R2: A `sys_rst_evt` pulse while the event counter is zero loads the register with 0x80000000, clearing every other bit.
- R3: A `sys_rst_evt` pulse while the event counter is non-zero leaves the register contents unchanged.
- R4: Bits 31, 28 and 27 are cleared by writing 1. Writing 0 to them leaves them unchanged.
- R5: Bits 30 and 29 are set by writing 1. Writing 0 never clears them; only an R2 load clears them.
- R6: Bits 26:0 ignore written data and always read 0.
- R7: A write with bit 30 set drives `sys_rst_req` high for exactly the one cycle after the write edge. The same write zeroes the event counter, so the next event applies R2.
- R8: A write with bit 29 set and bit 30 clear also pulses `sys_rst_req`, but leaves the event counter unchanged.
- R9: Only a bus access at the slot base + 4 (address bit 2 set) reaches the register. A write at the lower word or at any other address is ignored, and a read there returns 0.
- R10: The event counter saturates at its maximum. Any number of further events never brings it back to zero.
- R11: If a write is accepted in the same cycle as `sys_rst_evt`, the write is dropped completely: no bit changes, no request pulse and no counter clear.
- R12: A pulse on `btn_cause[1]` sets bit 28 and a pulse on `btn_cause[0]` sets bit 27. A button set wins over a same-cycle write-one clear of that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| btn_cause | input | 2 | Debounced button pulses: [1] power-on, [0] external-initiated |
| sys_rst_evt | input | 1 | One-cycle pulse reporting that a system reset happened |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench drives sequences that tell the counter paths apart.

- **Counter clear on a software power-on request.** After such a request, the next event must restore the power-on pattern. A design that did not clear the counter would keep the software bits instead.
- **Request without a counter clear.** After an external-initiated request, the next event must leave the register alone. A design that cleared the counter here too would reload 0x80000000.
- **Saturation.** Bit 31 is cleared and then more events are sent than the counter can represent. A wrapping counter would reach zero and bring the power-on bit back.
- **Collisions.** A write in the same cycle as an event must vanish completely. A button pulse in the same cycle as a write-one clear must win. The lower word and foreign addresses must show no effect, neither in read data nor as a request pulse.

// File: rtl/rcause_pkg.sv
package rcause_pkg;
   localparam int unsigned DATA_W    = 32;
   localparam int unsigned FIELD_W   = 5;
   localparam int unsigned FIELD_LSB = DATA_W - FIELD_W;

   // field bit index (register bit = FIELD_LSB + index)
   localparam int unsigned IX_POR  = 4;
   localparam int unsigned IX_SPOR = 3;
   localparam int unsigned IX_SXIR = 2;
   localparam int unsigned IX_BPOR = 1;
   localparam int unsigned IX_BXIR = 0;

   typedef logic [FIELD_W-1:0] cause_t;

   localparam cause_t W1C_BITS = cause_t'(5'b10011);
   localparam cause_t SET_BITS = cause_t'(5'b01100);
   localparam cause_t POR_LOAD = cause_t'(5'b10000);
endpackage

// File: rtl/rcause_decode.sv
module rcause_decode #(
   parameter int unsigned ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] SLOT_BASE = '0
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              wr_hit,
   output logic              rd_hit
);
   localparam int unsigned SLOT_LSB = 3;

   if (ADDR_W < 4) begin : g_bad_width
      $error("rcause_decode: ADDR_W must be at least 4");
   end
   if (SLOT_BASE[SLOT_LSB-1:0] != '0) begin : g_bad_base
      $error("rcause_decode: SLOT_BASE must be 8-byte aligned");
   end

   logic slot_match;
   logic upper_word;

   assign slot_match = (bus_addr[ADDR_W-1:SLOT_LSB] == SLOT_BASE[ADDR_W-1:SLOT_LSB]);
   assign upper_word = bus_addr[2];
   assign wr_hit     = bus_sel &&  bus_wr && slot_match && upper_word;
   assign rd_hit     = bus_sel && !bus_wr && slot_match && upper_word;
endmodule

// File: rtl/rcause_counter.sv
module rcause_counter #(
   parameter int unsigned CNT_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic clr,
   output logic cnt_zero
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 1) begin : g_bad_cnt
      $error("rcause_counter: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             at_max;

   assign at_max   = (cnt_q == CNT_MAX);
   assign cnt_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (evt && !at_max) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R10: saturation holds the counter at its top value
   p_cnt_saturates_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (at_max && evt && !clr) |=> at_max);

   // R10: an event alone never lands the counter on zero
   p_evt_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !clr) |=> !cnt_zero);

   // R7: a clear request empties the counter
   p_clr_zeroes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt_zero);
endmodule

// File: rtl/rcause_status.sv
module rcause_status
   import rcause_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   evt,
   input  logic   cnt_zero,
   input  logic   wr_en,
   input  cause_t wval,
   input  cause_t hw_set,
   output cause_t field
);
   logic por_load;
   assign por_load = evt && cnt_zero;

   for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
      if (W1C_BITS[i]) begin : g_w1c
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               field[i] <= 1'b0;
            end else if (por_load) begin
               field[i] <= POR_LOAD[i];
            end else if (hw_set[i]) begin
               field[i] <= 1'b1;
            end else if (wr_en && wval[i]) begin
               field[i] <= 1'b0;
            end
         end
         // R12: a hardware cause always lands unless a power-on load happens
         p_hw_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_set[i] && !por_load) |=> field[i]);
      end else begin : g_set
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               field[i] <= 1'b0;
            end else if (por_load) begin
               field[i] <= POR_LOAD[i];
            end else if (wr_en && wval[i]) begin
               field[i] <= 1'b1;
            end
         end
         // R5: request bits cannot be cleared except by a power-on load
         p_set_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (field[i] && !por_load) |=> field[i]);
      end
   end

   // R2: a first-reset event leaves only the power-on bit
   p_por_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      por_load |=> (field == POR_LOAD));

   // R3, R11: an event with a non-zero count freezes the software-owned bits
   p_evt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !cnt_zero && hw_set == '0) |=> $stable(field));
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
   import rcause_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] SLOT_BASE = 16'h0A40,
   parameter int unsigned CNT_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [1:0]        btn_cause,
   input  logic              sys_rst_evt,
   output logic              sys_rst_req
);
   logic   wr_hit, rd_hit, wr_acc, cnt_zero, req_q;
   cause_t wval, hw_set, field;

   rcause_decode #(
      .ADDR_W    (ADDR_W),
      .SLOT_BASE (SLOT_BASE)
   ) u_decode (
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .wr_hit   (wr_hit),
      .rd_hit   (rd_hit)
   );

   // data outside the cause field is dropped here (R6)
   assign wval   = bus_wdata[DATA_W-1:FIELD_LSB];
   assign wr_acc = wr_hit && !sys_rst_evt;

   always_comb begin
      hw_set          = '0;
      hw_set[IX_BPOR] = btn_cause[1];
      hw_set[IX_BXIR] = btn_cause[0];
   end

   rcause_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (sys_rst_evt),
      .clr      (wr_acc && wval[IX_SPOR]),
      .cnt_zero (cnt_zero)
   );

   rcause_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (sys_rst_evt),
      .cnt_zero (cnt_zero),
      .wr_en    (wr_acc),
      .wval     (wval),
      .hw_set   (hw_set),
      .field    (field)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else begin
         req_q <= wr_acc && (wval[IX_SPOR] || wval[IX_SXIR]);
      end
   end

   assign sys_rst_req = req_q;
   assign bus_rdata   = rd_hit ? {field, {FIELD_LSB{1'b0}}} : '0;

   // R11: a write colliding with an event never produces a request
   p_evt_no_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_evt |=> !sys_rst_req);

   // R9: the lower word of the slot always reads zero
   p_lower_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_addr[2]) |-> (bus_rdata == '0));

   // R6: bits below the cause field always read zero
   p_low_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[FIELD_LSB-1:0] == '0);

   // R9: reads and idle cycles never raise a request on the next cycle
   p_no_req_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr) |=> !sys_rst_req);
endmodule

// File: tb/tb_rst_cause_reg.sv
module tb_rst_cause_reg;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 16;
   localparam logic [ADDR_W-1:0] BASE = 16'h0A40;
   localparam int CNT_W      = 4;
   localparam int SAT_EVENTS = (1 << CNT_W) + 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0, bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [1:0]        btn_cause = '0;
   logic              sys_rst_evt = 1'b0;
   logic              sys_rst_req;

   int checks = 0;
   int errors = 0;
   logic req_seen;

   always #(CLK_PERIOD/2) clk = ~clk;

   rst_cause_reg #(.ADDR_W(ADDR_W), .SLOT_BASE(BASE), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .btn_cause(btn_cause), .sys_rst_evt(sys_rst_evt), .sys_rst_req(sys_rst_req));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // write; optional same-cycle event; req_seen captured one cycle after the edge
   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic with_evt);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; sys_rst_evt = with_evt;
      @(negedge clk);
      req_seen = sys_rst_req;
      bus_sel = 1'b0; bus_wr = 1'b0; sys_rst_evt = 1'b0;
      @(negedge clk);
      checks++;
      if (sys_rst_req !== 1'b0) begin
         errors++;
         $display("FAIL R7 request pulse longer than one cycle actual=1 expected=0");
      end
   endtask

   task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic pulse_evt();
      @(negedge clk); sys_rst_evt = 1'b1;
      @(negedge clk); sys_rst_evt = 1'b0;
   endtask

   task automatic pulse_btn(input logic [1:0] b);
      @(negedge clk); btn_cause = b;
      @(negedge clk); btn_cause = '0;
   endtask

   task automatic t_reset();
      logic [31:0] r;
      bus_read(BASE + 4, r);
      check("R1 reset value", r, 32'h0);
      check("R1 request low", {31'b0, sys_rst_req}, 32'h0);
   endtask

   task automatic t_first_event();
      logic [31:0] r;
      pulse_evt();
      bus_read(BASE + 4, r);
      check("R2 first event loads power-on", r, 32'h8000_0000);
   endtask

   task automatic t_soft_por();
      logic [31:0] r;
      bus_write(BASE + 4, 32'h6000_0000, 1'b0);
      check("R7 soft power-on request pulse", {31'b0, req_seen}, 32'h1);
      bus_read(BASE + 4, r);
      check("R5 request bits set", r, 32'hE000_0000);
      pulse_evt();
      bus_read(BASE + 4, r);
      check("R7 counter cleared, R2 reload", r, 32'h8000_0000);
   endtask

   task automatic t_soft_xir();
      logic [31:0] r;
      bus_write(BASE + 4, 32'h2000_0000, 1'b0);
      check("R8 external request pulse", {31'b0, req_seen}, 32'h1);
      pulse_evt();
      bus_read(BASE + 4, r);
      check("R8 R3 later event keeps contents", r, 32'hA000_0000);
      bus_write(BASE + 4, 32'h0000_0000, 1'b0);
      check("R5 zero write gives no request", {31'b0, req_seen}, 32'h0);
      bus_read(BASE + 4, r);
      check("R5 R4 zero write leaves bits", r, 32'hA000_0000);
   endtask

   task automatic t_w1c_and_buttons();
      logic [31:0] r;
      bus_write(BASE + 4, 32'h8000_0000, 1'b0);
      bus_read(BASE + 4, r);
      check("R4 write one clears bit 31", r, 32'h2000_0000);
      pulse_btn(2'b10);
      pulse_btn(2'b01);
      bus_read(BASE + 4, r);
      check("R12 button causes set", r, 32'h3800_0000);
      bus_write(BASE + 4, 32'h1000_0000, 1'b0);
      bus_read(BASE + 4, r);
      check("R4 write one clears bit 28", r, 32'h2800_0000);
      // button set against a same-cycle clear of bit 27
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = BASE + 4; bus_wdata = 32'h0800_0000; btn_cause = 2'b01;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; btn_cause = 2'b00;
      bus_read(BASE + 4, r);
      check("R12 button beats clear", r, 32'h2800_0000);
   endtask

   task automatic t_low_bits();
      logic [31:0] r;
      bus_write(BASE + 4, 32'h07FF_FFFF, 1'b0);
      check("R6 low-bit write no request", {31'b0, req_seen}, 32'h0);
      bus_read(BASE + 4, r);
      check("R6 low bits ignored", r, 32'h2800_0000);
      bus_write(BASE + 4, 32'hFFFF_FFFF, 1'b0);
      bus_read(BASE + 4, r);
      check("R6 R4 R5 all-ones write", r, 32'h6000_0000);
   endtask

   task automatic t_address();
      logic [31:0] r;
      pulse_evt();
      bus_write(BASE, 32'hE000_0000, 1'b0);
      check("R9 lower word write no request", {31'b0, req_seen}, 32'h0);
      bus_write(BASE + 16'h0010, 32'hE000_0000, 1'b0);
      check("R9 foreign write no request", {31'b0, req_seen}, 32'h0);
      bus_read(BASE + 4, r);
      check("R9 register untouched", r, 32'h8000_0000);
      bus_read(BASE, r);
      check("R9 lower word reads zero", r, 32'h0);
      bus_read(BASE + 16'h0014, r);
      check("R9 foreign read zero", r, 32'h0);
   endtask

   task automatic t_collision();
      logic [31:0] r;
      bus_write(BASE + 4, 32'h2000_0000, 1'b0);
      bus_write(BASE + 4, 32'h4000_0000, 1'b1);
      check("R11 no request on collision", {31'b0, req_seen}, 32'h0);
      bus_read(BASE + 4, r);
      check("R11 collided write dropped", r, 32'hA000_0000);
      pulse_evt();
      bus_read(BASE + 4, r);
      check("R11 counter not cleared", r, 32'hA000_0000);
   endtask

   task automatic t_saturate();
      logic [31:0] r;
      bus_write(BASE + 4, 32'h8000_0000, 1'b0);
      for (int i = 0; i < SAT_EVENTS; i++) pulse_evt();
      bus_read(BASE + 4, r);
      check("R10 counter saturates", r, 32'h2000_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_first_event();
      t_soft_por();
      t_soft_xir();
      t_w1c_and_buttons();
      t_low_bits();
      t_address();
      t_collision();
      t_saturate();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule